// File: doc/BRIEF.md
# Trace Sample Word Packer

The packer sits between a narrow trace port and a 32-bit trace buffer. Every accepted sample carries a 3-bit pipeline status, a packet field and a sync flag, and is turned into a fixed-width lane. The lane is 8, 12 or 20 bits wide, depending on the configured port width. Lanes are placed side by side in a 32-bit word. As soon as the word holds as many lanes as fit, it is handed to the buffer with a one-cycle valid strobe.

A sample that marks a trigger cycle is encoded in a special way. Its status field carries a reserved escape code, and its real status moves into the low three bits of the packet field. The port mode (plain, demultiplexed, multiplexed) is checked against the port width, and unsupported combinations raise an error flag that blocks capture.

When capture is switched off, any partially filled word is pushed out with its empty lanes zeroed. The idle flag tells the controller that nothing is left pending.

Top module: `trace_word_packer`

## Requirements
- R1: With width code 0 (4-bit port), each sample forms an 8-bit lane: status in bits 2:0, packet bits 3:0 in lane bits 6:3, and sync in bit 7. The first, second and third accepted samples go to word bits 7:0, 15:8 and 23:16, and the word is emitted after the third.
- R2: With width code 1 (8-bit port), each sample forms a 12-bit lane: status in bits 2:0, packet bits 7:0 in lane bits 10:3, and sync in bit 11. Two lanes sit at word bits 11:0 and 23:12, and the word is emitted after the second.
- R3: With width code 2 (16-bit port), each sample forms a 20-bit lane: status in bits 2:0, packet in bits 18:3, and sync in bit 19. Every accepted sample produces its own word.
- R4: A sample with the trigger input set is encoded with status field = TRIG_CODE (default 3'b110). The packet field's low 3 bits hold the sample's real status, and the packet's higher bits are taken from the sample unchanged.
- R5: The mode code is 0 for plain, 1 for demultiplexed, 2 for multiplexed and 3 for reserved. `cfg_err` is high when the mode is 2 or 3, when the width code is 3, or when the mode is 1 with a width code other than 1.
- R6: A sample is ignored while `run` is low or `cfg_err` is high. It produces no word and occupies no lane.
- R7: Word bits above the lanes used by the current width are zero. These are bits 31:24 in widths 0 and 1, and bits 31:20 in width 2.
- R8: When `run` is low and a partial word is pending, that word is emitted on the next clock edge with its unfilled lanes zero. The next word after that starts again at the lowest lane.
- R9: `idle` is high exactly when `run` is low and no partial word is pending.
- R10: `word_valid` is high for one cycle per emitted word, in the cycle after the clock edge that accepted the completing sample or performed the flush. `word_data` holds that word while `word_valid` is high.
- R11: After reset, `word_valid` is low, `word_data` is zero and no lane is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Port width code: 0=4, 1=8, 2=16 bits, 3=invalid |
| cfg_mode | input | 2 | Port mode: 0 plain, 1 demultiplexed, 2 multiplexed, 3 reserved |
| run | input | 1 | Capture enable; low requests flush |
| smp_valid | input | 1 | Sample present this cycle |
| smp_stat | input | 3 | Pipeline status of the sample |
| smp_pkt | input | 16 | Packet field (low bits used in narrow modes) |
| smp_sync | input | 1 | Sync flag of the sample |
| smp_trig | input | 1 | Sample is a trigger cycle |
| cfg_err | output | 1 | Unsupported mode/width combination |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_data | output | 32 | Packed word |
| idle | output | 1 | Capture off and nothing pending |

## Verification
Two functions can fall in the same cycle: trigger substitution and word completion, when the sample that fills the last lane is itself a trigger cycle. The bench provokes this in both multi-lane widths by marking the final sample of a word as a trigger. It also puts a trigger on a first lane, which is later pushed out by a flush. The reference model encodes each lane on its own and places it by arrival count, so an escape code landing in the wrong lane shows up as a mismatch on the completed or flushed word.

// File: rtl/trace_word_packer.sv
module trace_word_packer #(
  parameter logic [2:0] TRIG_CODE = 3'b110,
  parameter int         PKT_W     = 16,
  parameter int         WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_width,
  input  logic [1:0]        cfg_mode,
  input  logic              run,
  input  logic              smp_valid,
  input  logic [2:0]        smp_stat,
  input  logic [PKT_W-1:0]  smp_pkt,
  input  logic              smp_sync,
  input  logic              smp_trig,
  output logic              cfg_err,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              idle
);
  localparam int L4  = 8;
  localparam int L8  = 12;
  localparam int L16 = PKT_W + 4;

  logic [WORD_W-1:0] acc, acc_nxt, lane_sh;
  logic [1:0]        fill, last;
  logic [2:0]        st_f;
  logic [PKT_W-1:0]  pk_f;
  logic [L4-1:0]     lane4;
  logic [L8-1:0]     lane8;
  logic [L16-1:0]    lane16;
  logic              take, flush;

  assign cfg_err = cfg_mode[1] || (cfg_width == 2'd3) ||
                   (cfg_mode == 2'd1 && cfg_width != 2'd1);
  assign take    = run && smp_valid && !cfg_err;
  assign flush   = !run && (fill != 2'd0);
  assign idle    = !run && (fill == 2'd0);
  assign last    = (cfg_width == 2'd0) ? 2'd2 : (cfg_width == 2'd1) ? 2'd1 : 2'd0;

  assign st_f   = smp_trig ? TRIG_CODE : smp_stat;
  assign pk_f   = smp_trig ? {smp_pkt[PKT_W-1:3], smp_stat} : smp_pkt;
  assign lane4  = {smp_sync, pk_f[3:0], st_f};
  assign lane8  = {smp_sync, pk_f[7:0], st_f};
  assign lane16 = {smp_sync, pk_f, st_f};

  always_comb begin
    lane_sh = '0;
    case (cfg_width)
      2'd0: lane_sh = WORD_W'(lane4) << (L4 * int'(fill));
      2'd1: lane_sh = WORD_W'(lane8) << (L8 * int'(fill));
      default: lane_sh = WORD_W'(lane16);
    endcase
  end
  assign acc_nxt = acc | lane_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      fill       <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (take) begin
        if (fill >= last) begin
          word_data  <= acc_nxt;
          word_valid <= 1'b1;
          acc        <= '0;
          fill       <= '0;
        end else begin
          acc  <= acc_nxt;
          fill <= fill + 2'd1;
        end
      end else if (flush) begin
        word_data  <= acc;
        word_valid <= 1'b1;
        acc        <= '0;
        fill       <= '0;
      end
    end
  end

  AST_FILL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fill != 2'd3); // R1
  AST_COMPLETE_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fill >= last) |=> word_valid); // R10
  AST_FLUSH_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && fill != 2'd0) |=> (word_valid && fill == 2'd0)); // R8
  AST_IGNORED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_err || !run) && fill == 2'd0) |=> (!word_valid && fill == 2'd0)); // R6
  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_data[WORD_W-1:24] == '0); // R7
endmodule

// File: tb/sim_trace_word_packer.sv
module sim_trace_word_packer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_width = 2'd0, cfg_mode = 2'd0;
  logic run = 1'b0, smp_valid = 1'b0, smp_sync = 1'b0, smp_trig = 1'b0;
  logic [2:0] smp_stat = '0;
  logic [15:0] smp_pkt = '0;
  logic cfg_err, word_valid, idle;
  logic [31:0] word_data;

  always #10 clk = ~clk;

  trace_word_packer u0 (.clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_mode(cfg_mode),
    .run(run), .smp_valid(smp_valid), .smp_stat(smp_stat), .smp_pkt(smp_pkt),
    .smp_sync(smp_sync), .smp_trig(smp_trig), .cfg_err(cfg_err), .word_valid(word_valid),
    .word_data(word_data), .idle(idle));

  int n_cmp = 0, n_bad = 0;
  bit chk_en = 0;
  string ph = "R10";
  int mfill = 0;
  logic [31:0] macc = '0, exp_data = '0;
  bit exp_valid = 0;
  string exp_tag = "R1";
  int exp_used = 24;

  task automatic check(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_err();
    return cfg_mode >= 2 || cfg_width == 3 || (cfg_mode == 1 && cfg_width != 1);
  endfunction

  always @(posedge clk) begin
    int lw, lanes;
    logic [31:0] lane;
    int pk, st;
    exp_valid = 0;
    if (!rst_n) begin
      mfill = 0; macc = '0; exp_data = '0;
    end else begin
      lw    = (cfg_width == 0) ? 8 : (cfg_width == 1) ? 12 : 20;
      lanes = (cfg_width == 0) ? 3 : (cfg_width == 1) ? 2 : 1;
      if (run && smp_valid && !m_err()) begin
        pk = smp_trig ? ((smp_pkt & 16'hfff8) | smp_stat) : smp_pkt;
        pk = pk & ((1 << (lw - 4)) - 1);
        st = smp_trig ? 6 : smp_stat;
        lane = 32'(st) | (32'(pk) << 3) | (32'(smp_sync) << (lw - 1));
        macc = macc | (lane << (mfill * lw));
        mfill++;
        if (mfill == lanes) begin
          exp_valid = 1; exp_data = macc; macc = '0; mfill = 0;
          exp_used = lanes * lw;
          exp_tag = (ph == "R4") ? "R4" : (cfg_width == 0) ? "R1" : (cfg_width == 1) ? "R2" : "R3";
        end
      end else if (!run && mfill != 0) begin
        exp_valid = 1; exp_data = macc; macc = '0; mfill = 0;
        exp_used = lanes * lw; exp_tag = "R8";
      end
    end
  end

  always @(negedge clk) if (chk_en) begin
    check(ph, word_valid, exp_valid);
    if (exp_valid) begin
      check(exp_tag, word_data, exp_data);
      check("R7", word_data >> exp_used, 0);
    end
    check("R9", idle, !run && mfill == 0);
    check("R5", cfg_err, m_err());
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic smp(input logic [2:0] st, input logic [15:0] pk, input bit sy, input bit tg);
    tick(); smp_valid = 1; smp_stat = st; smp_pkt = pk; smp_sync = sy; smp_trig = tg;
  endtask
  task automatic gap(); tick(); smp_valid = 0; smp_trig = 0; endtask
  task automatic set_run(input bit r); tick(); smp_valid = 0; smp_trig = 0; run = r; endtask
  task automatic cfg(input logic [1:0] w, input logic [1:0] m); tick(); cfg_width = w; cfg_mode = m; endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    check("R11", word_valid, 0);
    check("R11", word_data, 0);
    check("R11", idle, 1);
    chk_en = 1;
    // R1: 4-bit lanes, two full words with a gap, then partial flush (R8)
    cfg(2'd0, 2'd0); set_run(1);
    smp(3'd1, 16'h000a, 1, 0); smp(3'd2, 16'h0005, 0, 0); gap();
    smp(3'd7, 16'h000f, 1, 0); smp(3'd4, 16'h0003, 0, 0);
    smp(3'd0, 16'hfff9, 1, 0);
    ph = "R4"; smp(3'd5, 16'h000c, 1, 1); ph = "R10";
    smp(3'd3, 16'h0001, 0, 1); set_run(0); gap(); gap();
    // R2: 8-bit lanes, trigger on the completing sample
    cfg(2'd1, 2'd0); set_run(1);
    smp(3'd2, 16'h00a5, 1, 0); ph = "R4"; smp(3'd3, 16'h005a, 0, 1); ph = "R10";
    smp(3'd6, 16'h00ff, 1, 0); set_run(0); gap();
    // R3: 16-bit, back-to-back words
    cfg(2'd2, 2'd0); set_run(1);
    smp(3'd1, 16'hbeef, 1, 0); ph = "R4"; smp(3'd7, 16'h1234, 0, 1); ph = "R10";
    smp(3'd0, 16'hffff, 1, 0); set_run(0); gap();
    // demultiplexed with 8-bit is allowed
    cfg(2'd1, 2'd1); set_run(1);
    smp(3'd4, 16'h0011, 0, 0); smp(3'd5, 16'h0022, 1, 0); set_run(0);
    // R5 R6: error configurations ignore samples
    ph = "R6";
    cfg(2'd1, 2'd2); set_run(1); smp(3'd1, 16'h1, 1, 0); smp(3'd2, 16'h2, 1, 0); set_run(0);
    cfg(2'd0, 2'd1); set_run(1); smp(3'd1, 16'h1, 1, 0); smp(3'd2, 16'h2, 1, 0); set_run(0);
    cfg(2'd3, 2'd0); set_run(1); smp(3'd3, 16'h3, 0, 0); set_run(0);
    cfg(2'd2, 2'd3); set_run(1); smp(3'd3, 16'h3, 0, 0); set_run(0);
    cfg(2'd0, 2'd0); smp(3'd6, 16'h7, 1, 0); smp(3'd6, 16'h7, 1, 0); gap();
    ph = "R10";
    // mixed bursts in each valid width
    for (int w = 0; w < 3; w++) begin
      cfg(2'(w), 2'd0); set_run(1);
      for (int k = 0; k < 40; k++) begin
        if ($urandom_range(0, 3) == 0) gap();
        else smp(3'($urandom), 16'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0));
      end
      set_run(0); gap(); gap();
    end
    chk_en = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule